// File: doc/BRIEF.md
# Masked Two-Source Interrupt Controller

This block merges two interrupt causes into one level-high request line for a host interrupt controller that reacts to rising edges. One cause is an external attention line that is active low; the other is the interface-ready flag from the handshake logic. Each cause has its own mask bit, and one global enable bit gates the merged result. The request is registered, so it changes one clock after the state that produces it.

Software writes an 8-bit mask register and a separate enable register through a simple write port with a one-bit register select. It reads the mask back unchanged, and reads a status byte that shows the live request and the stored global enable. A reset from the handshake block clears the global enable and leaves the mask alone. Because the host detects edges, a handler re-arms the line by clearing the global enable and then setting it again. This forces the request low for at least one cycle, so any cause that is still pending produces a new rising edge.

Top module: `dual_irq_ctrl`

## Requirements
- R1: With mask bit 0 set and the global enable set, `irq_o` is 1 whenever `ext_irq_ni` is 0.
- R2: With mask bit 1 set and the global enable set, `irq_o` is 1 whenever `ready_i` is 1.
- R3: While the global enable (enable register bit 3) is 0, `irq_o` is 0 for every mask value and input level.
- R4: `irq_o` equals enable AND ((mask[0] AND NOT ext_irq_ni) OR (mask[1] AND ready_i)), evaluated on the values present one clock edge earlier.
- R5: A write with `wr_sel_i`=0 stores all 8 data bits in the mask register, and `mask_o` returns exactly that value after the write edge.
- R6: `status_o` bit 2 equals `irq_o`, bit 3 equals the stored global enable, and bits 7:4 and 1:0 are always 0.
- R7: A write with `wr_sel_i`=1 stores only data bit 3 as the global enable. All other bits of that write have no effect.
- R8: `iface_rst_i` clears the global enable at the next edge and wins over an enable write in the same cycle. The mask register is kept.
- R9: A write that clears the global enable, followed directly by a write that sets it, holds `irq_o` at 0 for at least one cycle before a pending cause raises it again.
- R10: After `rst_ni` is released, `mask_o`, `status_o` and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iface_rst_i | input | 1 | Interface reset from the handshake block, one-cycle pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 is the mask register, 1 is the enable register |
| wr_data_i | input | 8 | Write data |
| ext_irq_ni | input | 1 | Synchronized external interrupt line, active low |
| ready_i | input | 1 | Interface-ready level |
| mask_o | output | 8 | Mask register readback |
| status_o | output | 8 | Status byte: bit 3 is the global enable, bit 2 is the live request |
| irq_o | output | 1 | Registered interrupt request, active high |

## Verification
The assertions assume that `ext_irq_ni` and `ready_i` are already synchronous to `clk_i`. They also assume that every write and interface-reset strobe is a clean level sampled at one rising edge. The bench meets these assumptions by changing every input only on the falling edge. It sweeps all 256 mask values against both enable states and all four source level combinations. The enable writes carry varied junk in their unused bits, and the bench computes the expected request from the sum-of-products formula one edge later.

// File: rtl/dual_irq_pkg.sv
package dual_irq_pkg;
  localparam int unsigned MASK_EXT_BIT = 0;
  localparam int unsigned MASK_RDY_BIT = 1;
  localparam int unsigned STAT_REQ_BIT = 2;
  localparam int unsigned GEN_BIT      = 3;
  localparam logic        SEL_MASK     = 1'b0;
  localparam logic        SEL_ENABLE   = 1'b1;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import dual_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              iface_rst_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] mask_o,
  output logic              gen_en_o
);
  logic [DATA_W-1:0] mask_q;
  logic              gen_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (wr_en_i && wr_sel_i == SEL_MASK) begin
      mask_q <= wr_data_i;
    end
  end

  // interface reset outranks a same-cycle enable write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gen_en_q <= 1'b0;
    end else if (iface_rst_i) begin
      gen_en_q <= 1'b0;
    end else if (wr_en_i && wr_sel_i == SEL_ENABLE) begin
      gen_en_q <= wr_data_i[GEN_BIT];
    end
  end

  assign mask_o   = mask_q;
  assign gen_en_o = gen_en_q;

  // R5
  mask_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_MASK) |=> (mask_o == $past(wr_data_i)));

  // R8
  iface_rst_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iface_rst_i |=> !gen_en_o);

  // R8
  iface_rst_keeps_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iface_rst_i && !(wr_en_i && wr_sel_i == SEL_MASK)) |=> $stable(mask_o));
endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mask_ext_i,
  input  logic mask_rdy_i,
  input  logic gen_en_i,
  input  logic ext_irq_ni,
  input  logic ready_i,
  output logic irq_o
);
  logic ext_hit, rdy_hit, irq_d, irq_q;

  assign ext_hit = mask_ext_i & ~ext_irq_ni;
  assign rdy_hit = mask_rdy_i & ready_i;
  assign irq_d   = gen_en_i & (ext_hit | rdy_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  // R3
  gen_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(gen_en_i));

  // R1
  // R2
  source_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past((mask_ext_i && !ext_irq_ni) || (mask_rdy_i && ready_i)));
endmodule

// File: rtl/irq_status_view.sv
module irq_status_view
  import dual_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              gen_en_i,
  input  logic              irq_i,
  output logic [DATA_W-1:0] status_o
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b == GEN_BIT) begin : g_gen
      assign status_o[b] = gen_en_i;
    end else if (b == STAT_REQ_BIT) begin : g_req
      assign status_o[b] = irq_i;
    end else begin : g_zero
      assign status_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
  import dual_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              iface_rst_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ext_irq_ni,
  input  logic              ready_i,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] status_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] mask_w;
  logic              gen_en_w;
  logic              irq_w;

  irq_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .iface_rst_i(iface_rst_i),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .mask_o     (mask_w),
    .gen_en_o   (gen_en_w)
  );

  irq_req_gen u_req (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mask_ext_i(mask_w[MASK_EXT_BIT]),
    .mask_rdy_i(mask_w[MASK_RDY_BIT]),
    .gen_en_i  (gen_en_w),
    .ext_irq_ni(ext_irq_ni),
    .ready_i   (ready_i),
    .irq_o     (irq_w)
  );

  irq_status_view #(.DATA_W(DATA_W)) u_stat (
    .gen_en_i(gen_en_w),
    .irq_i   (irq_w),
    .status_o(status_o)
  );

  assign mask_o = mask_w;
  assign irq_o  = irq_w;

  // R9
  rearm_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o[GEN_BIT]) |=> !irq_o);

  // R7
  enable_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_ENABLE && !iface_rst_i)
      |=> (status_o[GEN_BIT] == $past(wr_data_i[GEN_BIT])));
endmodule

// File: tb/dual_irq_ctrl_test.sv
module dual_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       iface_rst = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic       ext_n = 1'b1;
  logic       rdy = 1'b0;
  logic [7:0] mask_rd, status_rd;
  logic       irq;

  int unsigned n_checks = 0;
  int unsigned n_fail = 0;

  always #10 clk = ~clk;

  dual_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .iface_rst_i(iface_rst),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .ext_irq_ni(ext_n), .ready_i(rdy),
    .mask_o(mask_rd), .status_o(status_rd), .irq_o(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // drive at negedge, latched at next posedge, strobe dropped at following negedge
  task automatic reg_write(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [7:0] exp_status(input logic en, input logic rq);
    return {4'b0, en, rq, 2'b00};
  endfunction

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 mask", mask_rd, 8'h00);
    check("R10 status", status_rd, 8'h00);
    check("R10 irq", {7'b0, irq}, 8'h00);

    // sweep: R1 R2 R3 R4 R5 R6 R7
    for (int m = 0; m < 256; m++) begin
      for (int e = 0; e < 2; e++) begin
        logic [7:0] junk;
        junk = (8'(m) ^ 8'h5A) & 8'hF7;
        reg_write(1'b0, 8'(m));
        check("R5 mask readback", mask_rd, 8'(m));
        reg_write(1'b1, junk | (e[0] ? 8'h08 : 8'h00));
        for (int s = 0; s < 4; s++) begin
          logic xl, rl, ex;
          xl = s[0]; rl = s[1];
          ext_n = ~xl; rdy = rl;
          @(posedge clk); @(negedge clk);
          ex = e[0] & ((m[0] & xl) | (m[1] & rl));
          if (m[0] && e[0] && xl)
            check("R1 ext source", {7'b0, irq}, 8'h01);
          else if (m[1] && e[0] && rl)
            check("R2 ready source", {7'b0, irq}, 8'h01);
          else if (!e[0])
            check("R3 gated off", {7'b0, irq}, 8'h00);
          else
            check("R4 request", {7'b0, irq}, {7'b0, ex});
          check("R6 R7 status", status_rd, exp_status(e[0], ex));
        end
      end
    end

    // R4 one-edge latency: input change not visible before the edge
    reg_write(1'b0, 8'h02);
    reg_write(1'b1, 8'h08);
    rdy = 1'b0; ext_n = 1'b1;
    @(posedge clk); @(negedge clk);
    rdy = 1'b1;
    #5 check("R4 before edge", {7'b0, irq}, 8'h00);
    @(negedge clk);
    check("R4 after edge", {7'b0, irq}, 8'h01);

    // R9 re-arm: clear then set enable
    reg_write(1'b1, 8'h00);
    check("R9 old request held", {7'b0, irq}, 8'h01);
    reg_write(1'b1, 8'h08);
    check("R9 gap low", {7'b0, irq}, 8'h00);
    @(negedge clk);
    check("R9 new edge", {7'b0, irq}, 8'h01);

    // R8 interface reset beats same-cycle enable write, mask kept
    iface_rst = 1'b1;
    reg_write(1'b1, 8'h08);
    iface_rst = 1'b0;
    check("R8 enable cleared", status_rd & 8'h08, 8'h00);
    check("R8 mask kept", mask_rd, 8'h02);
    @(negedge clk);
    check("R8 irq dropped", {7'b0, irq}, 8'h00);
    check("R8 status", status_rd, 8'h00);

    // R7 enable write with only junk bits leaves enable clear
    reg_write(1'b1, 8'hF7);
    @(negedge clk);
    check("R7 junk bits", status_rd, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule